// File: doc/BRIEF.md
# Low-Power Entry and Interrupt Wakeup Controller

This block sits between a processor core and its interrupt logic and decides when the core's clocks may be switched off and when they must come back. Software first programs a small register set over a simple write/read bus. The registers are a control byte, a low-power mode selector and a per-mode mask for programmable interrupt sources. The control byte holds a stop-permission bit and a 3-bit wake threshold. When the core later reports that it has executed its STOP instruction, the controller checks whether that entry is permitted in the selected mode. If it is, the controller first removes the core clock enable. On the following cycle it arms its wakeup comparison.

While the clocks are off, every cycle compares the priority of the pending interrupt against the threshold. It also checks whether the source type may end the current mode. Stop mode can only be ended by a fixed external source. Wait and doze can be ended by a fixed source, or by a programmable source whose mode mask bit is set. A qualifying request is registered. That registered decision restores the clock enable and emits a one-cycle exit request. A low-power status output stays high from clock gating until the core acknowledges the wake.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: After reset all three registers read as zero, `core_clk_en` is 1, `lp_active` is 0 and `exit_req` is 0.
- R2: The control register at address 0 keeps the stop-permission bit in bit 7 and the wake threshold in bits 6:4. Bits 3:0 always read as zero.
- R3: The mode register at address 1 uses bits 1:0, with 00 = run, 01 = wait, 10 = doze and 11 = stop. The mask register at address 2 uses bit 0 to allow programmable sources in wait and bit 1 to allow them in doze. All other bits of both registers read as zero.
- R4: A `stop_exec` pulse in wait mode, in doze mode, or in stop mode with the permission bit set makes `core_clk_en` go 0 and `lp_active` go 1 on the next cycle.
- R5: A `stop_exec` pulse in run mode, or in stop mode with the permission bit clear, is ignored: `core_clk_en` stays 1 and `lp_active` stays 0.
- R6: After gating, `core_clk_en` stays 0 for at least two cycles. A request present during the first gated cycle is not yet accepted.
- R7: A wake requires `irq_level` strictly greater than the programmed threshold. A level equal to or below it never wakes.
- R8: In stop mode only a request with `irq_fixed` = 1 can wake the device.
- R9: In wait or doze mode a fixed request always qualifies. A programmable request (`irq_fixed` = 0) qualifies only if the mask bit for that mode is set.
- R10: A qualifying request sampled at a clock edge makes `exit_req` high for exactly one cycle after that edge, with `core_clk_en` already 1 in that cycle.
- R11: `lp_active` stays 1 after the wake until `wake_ack` is sampled high, and is 0 in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 mode, 2 mask) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| stop_exec | input | 1 | Core reports that STOP has executed and it has halted |
| irq_level | input | 3 | Priority of the pending interrupt, 0 = none |
| irq_fixed | input | 1 | 1 = pending request is from a fixed external source |
| wake_ack | input | 1 | Core acknowledges the wake |
| core_clk_en | output | 1 | Enable for the core clocks |
| exit_req | output | 1 | One-cycle request to leave low-power mode |
| lp_active | output | 1 | High from clock gating until the wake is acknowledged |

## Verification
The embedded properties check several rules on every cycle. The exit request is always a single pulse and coincides with enabled clocks. The clock stays gated for two cycles once it falls. The status flag covers every gated cycle. An ignored STOP leaves the clocks running. Every exit was preceded by a level above the threshold, and by a fixed source when the mode is stop. The bench scenarios show what no single-cycle property can. These are the register layout, that disallowed sources and levels at or below the threshold really keep the device asleep across several cycles, the per-mode mask choices, and the exact cycle at which exit and acknowledge take effect.

// File: rtl/lpm_wake_pkg.sv
package lpm_wake_pkg;
    localparam int REG_W     = 8;
    localparam int CTRL_ADDR = 0;
    localparam int MODE_ADDR = 1;
    localparam int MASK_ADDR = 2;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_WAIT = 2'b01,
        MODE_DOZE = 2'b10,
        MODE_STOP = 2'b11
    } lp_mode_e;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_GATE,
        ST_ARMED,
        ST_WAKE,
        ST_ACKW
    } seq_state_e;
endpackage

// File: rtl/lpm_wake_regs.sv
module lpm_wake_regs
    import lpm_wake_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int LVL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              stop_en,
    output logic [LVL_W-1:0]  thr,
    output lp_mode_e          mode,
    output logic [1:0]        mask,
    output logic              entry_ok
);
    localparam int EN_BIT  = REG_W - 1;
    localparam int THR_MSB = EN_BIT - 1;
    localparam int THR_LSB = EN_BIT - LVL_W;

    typedef struct packed {
        logic             stop_en;
        logic [LVL_W-1:0] thr;
        lp_mode_e         mode;
        logic [1:0]       mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (int'(addr))
                CTRL_ADDR: begin
                    cfg_d.stop_en = wdata[EN_BIT];
                    cfg_d.thr     = wdata[THR_MSB:THR_LSB];
                end
                MODE_ADDR: cfg_d.mode = lp_mode_e'(wdata[1:0]);
                MASK_ADDR: cfg_d.mask = wdata[1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{stop_en: 1'b0, thr: '0, mode: MODE_RUN, mask: 2'b00};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (int'(addr))
            CTRL_ADDR: begin
                rdata[EN_BIT]          = cfg_q.stop_en;
                rdata[THR_MSB:THR_LSB] = cfg_q.thr;
            end
            MODE_ADDR: rdata[1:0] = cfg_q.mode;
            MASK_ADDR: rdata[1:0] = cfg_q.mask;
            default: ;
        endcase
    end

    assign stop_en  = cfg_q.stop_en;
    assign thr      = cfg_q.thr;
    assign mode     = cfg_q.mode;
    assign mask     = cfg_q.mask;
    assign entry_ok = (cfg_q.mode != MODE_RUN) &&
                      ((cfg_q.mode != MODE_STOP) || cfg_q.stop_en);
endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual
    import lpm_wake_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  lp_mode_e         mode,
    input  logic [LVL_W-1:0] thr,
    input  logic [1:0]       mask,
    input  logic [LVL_W-1:0] irq_level,
    input  logic             irq_fixed,
    output logic             qualify
);
    logic above;
    logic src_ok;

    assign above = irq_level > thr;

    always_comb begin
        case (mode)
            MODE_STOP: src_ok = irq_fixed;
            MODE_WAIT: src_ok = irq_fixed || mask[0];
            MODE_DOZE: src_ok = irq_fixed || mask[1];
            default:   src_ok = 1'b0;
        endcase
    end

    assign qualify = above && src_ok;
endmodule

// File: rtl/lpm_wake_seq.sv
module lpm_wake_seq
    import lpm_wake_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     stop_exec,
    input  logic     entry_ok,
    input  lp_mode_e mode_cfg,
    input  logic     qualify,
    input  logic     wake_ack,
    output lp_mode_e act_mode,
    output logic     core_clk_en,
    output logic     exit_req,
    output logic     lp_active
);
    typedef struct packed {
        seq_state_e st;
        lp_mode_e   mode;
        logic       exit_p;
        logic       clk_en;
        logic       lp;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_RUN: begin
                if (stop_exec && entry_ok) begin
                    s_d.st   = ST_GATE;
                    s_d.mode = mode_cfg;
                end
            end
            ST_GATE:  s_d.st = ST_ARMED;
            ST_ARMED: if (qualify) s_d.st = ST_WAKE;
            ST_WAKE:  s_d.st = wake_ack ? ST_RUN : ST_ACKW;
            ST_ACKW:  if (wake_ack) s_d.st = ST_RUN;
            default:  s_d.st = ST_RUN;
        endcase
        s_d.exit_p = (s_d.st == ST_WAKE);
        s_d.clk_en = (s_d.st == ST_RUN) || (s_d.st == ST_WAKE) || (s_d.st == ST_ACKW);
        s_d.lp     = (s_d.st != ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_RUN, mode: MODE_RUN, exit_p: 1'b0, clk_en: 1'b1, lp: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign act_mode    = s_q.mode;
    assign core_clk_en = s_q.clk_en;
    assign exit_req    = s_q.exit_p;
    assign lp_active   = s_q.lp;

    p_exit_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |=> !exit_req);
    p_exit_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |-> core_clk_en);
    p_clk_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_clk_en) |=> !core_clk_en);
    p_gated_lp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !core_clk_en |-> lp_active);
    p_lp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_active && core_clk_en && !wake_ack) |=> lp_active);
    p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_active && stop_exec && !entry_ok) |=> (core_clk_en && !lp_active));
endmodule

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl
    import lpm_wake_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int LVL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              stop_exec,
    input  logic [LVL_W-1:0]  irq_level,
    input  logic              irq_fixed,
    input  logic              wake_ack,
    output logic              core_clk_en,
    output logic              exit_req,
    output logic              lp_active
);
    logic             stop_en_w;
    logic [LVL_W-1:0] thr_w;
    lp_mode_e         mode_w;
    lp_mode_e         act_mode_w;
    logic [1:0]       mask_w;
    logic             entry_ok_w;
    logic             qualify_w;

    lpm_wake_regs #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .stop_en  (stop_en_w),
        .thr      (thr_w),
        .mode     (mode_w),
        .mask     (mask_w),
        .entry_ok (entry_ok_w)
    );

    lpm_wake_qual #(.LVL_W(LVL_W)) u_qual (
        .mode      (act_mode_w),
        .thr       (thr_w),
        .mask      (mask_w),
        .irq_level (irq_level),
        .irq_fixed (irq_fixed),
        .qualify   (qualify_w)
    );

    lpm_wake_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_exec   (stop_exec),
        .entry_ok    (entry_ok_w),
        .mode_cfg    (mode_w),
        .qualify     (qualify_w),
        .wake_ack    (wake_ack),
        .act_mode    (act_mode_w),
        .core_clk_en (core_clk_en),
        .exit_req    (exit_req),
        .lp_active   (lp_active)
    );

    p_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |-> ($past(irq_level) > $past(thr_w)));
    p_stop_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_req && act_mode_w == MODE_STOP) |-> $past(irq_fixed));
    p_stop_perm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_active && stop_exec && mode_w == MODE_STOP && !stop_en_w) |=> !lp_active);
endmodule

// File: tb/lpm_wake_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_wake_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       stop_exec = 1'b0;
    logic [2:0] irq_level = '0;
    logic       irq_fixed = 1'b0;
    logic       wake_ack = 1'b0;
    logic       core_clk_en, exit_req, lp_active;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lpm_wake_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stop_exec(stop_exec),
        .irq_level(irq_level), .irq_fixed(irq_fixed), .wake_ack(wake_ack),
        .core_clk_en(core_clk_en), .exit_req(exit_req), .lp_active(lp_active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    function automatic bit exp_wake(input int mode, input int thr, input logic [1:0] mask,
                                    input int lvl, input bit fixed);
        if (lvl <= thr) return 1'b0;
        if (mode == 3) return fixed;
        if (fixed) return 1'b1;
        return (mode == 1) ? mask[0] : mask[1];
    endfunction

    function automatic bit exp_entry(input int mode, input bit en);
        return (mode != 0) && (mode != 3 || en);
    endfunction

    task automatic do_ack(input string req);
        @(negedge clk);
        chk(exit_req == 1'b0, "R10 pulse ends", exit_req, 0);
        chk(lp_active == 1'b1, "R11 lp held before ack", lp_active, 1);
        wake_ack = 1'b1;
        @(negedge clk);
        wake_ack = 1'b0;
        chk(lp_active == 1'b0, req, lp_active, 0);
        chk(core_clk_en == 1'b1, "R11 clocks after ack", core_clk_en, 1);
    endtask

    task automatic scenario(input int mode, input bit en, input int thr, input logic [1:0] mask,
                            input int lvl, input bit fixed);
        wr(2'd0, {en, thr[2:0], 4'hA});
        wr(2'd1, {6'h3F, mode[1:0]});
        wr(2'd2, {6'h2A, mask});
        irq_level = '0; irq_fixed = 1'b0;
        @(negedge clk);
        stop_exec = 1'b1;
        irq_level = 3'(lvl); irq_fixed = fixed;
        @(negedge clk);
        stop_exec = 1'b0;
        if (!exp_entry(mode, en)) begin
            chk(core_clk_en == 1'b1 && lp_active == 1'b0, "R5 STOP ignored", {core_clk_en, lp_active}, 2);
            @(negedge clk);
            chk(core_clk_en == 1'b1 && lp_active == 1'b0, "R5 still running", {core_clk_en, lp_active}, 2);
            irq_level = '0;
            return;
        end
        chk(core_clk_en == 1'b0 && lp_active == 1'b1, "R4 entry gates clocks", {core_clk_en, lp_active}, 1);
        @(negedge clk);
        chk(exit_req == 1'b0 && core_clk_en == 1'b0, "R6 first gated cycle no wake", {exit_req, core_clk_en}, 0);
        @(negedge clk);
        if (exp_wake(mode, thr, mask, lvl, fixed)) begin
            chk(exit_req == 1'b1 && core_clk_en == 1'b1, "R10 exit pulse with clocks (R7 R8 R9)",
                {exit_req, core_clk_en}, 3);
            do_ack("R11 lp clears after ack");
        end else begin
            for (int i = 0; i < 4; i++) begin
                chk(exit_req == 1'b0 && core_clk_en == 1'b0, "R7 R8 R9 stays asleep",
                    {exit_req, core_clk_en}, 0);
                @(negedge clk);
            end
            irq_level = 3'd7; irq_fixed = 1'b1;
            @(negedge clk);
            chk(exit_req == 1'b1, "R8 fixed high level wakes", exit_req, 1);
            do_ack("R11 lp clears after ack");
        end
        irq_level = '0; irq_fixed = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(core_clk_en == 1'b1 && lp_active == 1'b0 && exit_req == 1'b0, "R1 reset outputs",
            {core_clk_en, lp_active, exit_req}, 4);
        rd_chk(2'd0, 8'h00, "R1 ctrl reset");
        rd_chk(2'd1, 8'h00, "R1 mode reset");
        rd_chk(2'd2, 8'h00, "R1 mask reset");
        wr(2'd0, 8'hFF); rd_chk(2'd0, 8'hF0, "R2 ctrl layout");
        wr(2'd0, 8'hA5); rd_chk(2'd0, 8'hA0, "R2 ctrl fields");
        wr(2'd1, 8'hFE); rd_chk(2'd1, 8'h02, "R3 mode field");
        wr(2'd2, 8'hFF); rd_chk(2'd2, 8'h03, "R3 mask field");

        // directed corners
        scenario(0, 1, 0, 2'b11, 7, 1);  // R5 run mode ignored
        scenario(3, 0, 0, 2'b11, 7, 1);  // R5 stop without permission
        scenario(3, 1, 3, 2'b00, 4, 1);  // R8 stop fixed wakes
        scenario(3, 1, 3, 2'b11, 7, 0);  // R8 stop programmable rejected
        scenario(1, 0, 4, 2'b00, 4, 1);  // R7 equal level rejected
        scenario(1, 0, 4, 2'b00, 5, 1);  // R7 one above wakes
        scenario(1, 0, 2, 2'b01, 6, 0);  // R9 wait mask set
        scenario(1, 0, 2, 2'b10, 6, 0);  // R9 wait mask clear
        scenario(2, 0, 2, 2'b10, 6, 0);  // R9 doze mask set
        scenario(2, 0, 2, 2'b01, 6, 0);  // R9 doze mask clear
        scenario(2, 0, 0, 2'b00, 0, 1);  // R7 level zero never wakes

        for (int n = 0; n < 40; n++) begin
            scenario(int'($urandom_range(3, 0)), 1'($urandom), int'($urandom_range(6, 0)),
                     2'($urandom), int'($urandom_range(7, 0)), 1'($urandom));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule